// File: doc/BRIEF.md
# Alternate instruction bridge decoder

This block sits beside the instruction fetch path and watches the fetched byte stream for a wrapped instruction belonging to a hidden second instruction set. A wrapper is a three-byte prefix followed by a payload of four bytes. Two prefixes are recognised. The payload is reassembled into one 32-bit word and presented with a one-cycle strobe to the alternate execution path. Wrappers are honoured only while the core is in alternate mode.

The block also decodes a two-byte launch opcode. The opcode is a parameter. What the launch does depends on an enable bit held in a privileged feature-control register. With the bit set, the launch redirects fetch to the address on the accumulator input and puts the core into alternate mode. With the bit clear, the launch raises an invalid-instruction fault and leaves the mode alone. The feature-control register sits at index 0x1107. Only privileged writes may change it. A write changes the enable bit and nothing else. An unprivileged write raises a protection fault.

Top module: `alt_bridge_decoder`

## Requirements
- R1: While rst_ni is low, all pulse outputs and alt_mode_o are 0, the enable bit is 0, and csr_rdata_o reads the fixed pattern 0x000000A2 with the enable bit (bit 0) clear.
- R2: Once in alternate mode, a prefix 0x8D,0x84,0x00 followed by four payload bytes gives insn_valid_o high for exactly one cycle. The pulse comes in the cycle after the last payload byte is accepted. insn_o is little-endian: the first payload byte is bits [7:0] and the fourth is bits [31:24].
- R3: The prefix 0x62,0x04,0x05 followed by four payload bytes is extracted in the same way as in R2.
- R4: A byte that breaks a partial prefix match resets the matcher. If that byte is 0x8D or 0x62, it starts a new match. Any other breaking byte returns the matcher to idle.
- R5: A complete wrapper accepted while alt_mode_o is 0 produces no insn_valid_o pulse.
- R6: When the launch opcode 0x0F,0x3F completes with the enable bit set, redirect_valid_o pulses for one cycle carrying the accumulator value on redirect_addr_o. In the same cycle alt_mode_o goes high and then stays high. redirect_addr_o is zero whenever redirect_valid_o is low.
- R7: When the launch opcode completes with the enable bit clear, ud_fault_o pulses for one cycle, no redirect occurs, and alt_mode_o keeps its value.
- R8: A privileged write to index 0x1107 changes only bit 0 of the feature register. The other bits read back unchanged. The new value is visible on csr_rdata_o one cycle after the write.
- R9: An unprivileged write to index 0x1107 leaves the register unchanged and pulses prot_fault_o for one cycle.
- R10: A write to any other index changes nothing and raises no fault.
- R11: Bytes presented while byte_valid_i is low are not consumed, and the matcher keeps its progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | Fetch byte is valid this cycle |
| byte_i | input | 8 | Fetched byte |
| acc_i | input | 32 | Accumulator value, used as the redirect target |
| csr_we_i | input | 1 | Register write strobe |
| csr_priv_i | input | 1 | The write is privileged |
| csr_idx_i | input | 16 | Register index |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Feature register contents |
| prot_fault_o | output | 1 | Unprivileged write to the feature register |
| insn_valid_o | output | 1 | Extracted word valid |
| insn_o | output | 32 | Extracted payload word |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_addr_o | output | 32 | Fetch redirect target |
| ud_fault_o | output | 1 | Invalid-instruction fault |
| alt_mode_o | output | 1 | Core is in alternate mode |

## Verification
Both prefixes are sent with distinct payloads, so a byte-order error or a swap between the two prefixes shows up in the extracted word. Overlapping and broken prefixes separate a matcher that restarts on 0x8D or 0x62 from one that drops to idle or keeps its partial progress. A breaking byte that is not a prefix start checks that no stale state survives. Gaps in byte_valid_i check that the matcher holds its progress. The launch is tried with the enable bit clear, then set, then cleared again after mode entry. This separates redirect from fault and confirms that the mode does not drop.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_A1,
    ST_A2,
    ST_B1,
    ST_B2,
    ST_L1,
    ST_PAY
  } abd_state_e;
endpackage

// File: rtl/abd_matcher.sv
module abd_matcher #(
  parameter logic [7:0]  PFX_A0    = 8'h8D,
  parameter logic [7:0]  PFX_A1    = 8'h84,
  parameter logic [7:0]  PFX_A2    = 8'h00,
  parameter logic [7:0]  PFX_B0    = 8'h62,
  parameter logic [7:0]  PFX_B1    = 8'h04,
  parameter logic [7:0]  PFX_B2    = 8'h05,
  parameter logic [15:0] LAUNCH_OP = 16'h0F3F,
  parameter int unsigned PAY_BYTES = 4,
  localparam int unsigned W  = 8 * PAY_BYTES,
  localparam int unsigned CW = $clog2(PAY_BYTES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_valid_i,
  input  logic [7:0]   byte_i,
  output logic         wrap_hit_o,
  output logic [W-1:0] word_o,
  output logic         launch_hit_o
);
  import abd_pkg::*;

  abd_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  buf_q, buf_d;

  // a breaking byte may itself open a new sequence
  function automatic abd_state_e start_of(input logic [7:0] b);
    if (b == PFX_A0)              return ST_A1;
    else if (b == PFX_B0)         return ST_B1;
    else if (b == LAUNCH_OP[15:8]) return ST_L1;
    else                          return ST_IDLE;
  endfunction

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    buf_d        = buf_q;
    wrap_hit_o   = 1'b0;
    launch_hit_o = 1'b0;
    if (byte_valid_i) begin
      unique case (state_q)
        ST_IDLE: state_d = start_of(byte_i);
        ST_A1:   state_d = (byte_i == PFX_A1) ? ST_A2 : start_of(byte_i);
        ST_A2:   state_d = (byte_i == PFX_A2) ? ST_PAY : start_of(byte_i);
        ST_B1:   state_d = (byte_i == PFX_B1) ? ST_B2 : start_of(byte_i);
        ST_B2:   state_d = (byte_i == PFX_B2) ? ST_PAY : start_of(byte_i);
        ST_L1: begin
          if (byte_i == LAUNCH_OP[7:0]) begin
            launch_hit_o = 1'b1;
            state_d      = ST_IDLE;
          end else begin
            state_d = start_of(byte_i);
          end
        end
        ST_PAY: begin
          buf_d[{cnt_q, 3'b000} +: 8] = byte_i;
          if (cnt_q == CW'(PAY_BYTES - 1)) begin
            wrap_hit_o = 1'b1;
            cnt_d      = '0;
            state_d    = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
    word_o = buf_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      buf_q   <= buf_d;
    end
  end
endmodule

// File: rtl/abd_feature_reg.sv
module abd_feature_reg #(
  parameter int unsigned         IDX_W      = 16,
  parameter int unsigned         DW         = 32,
  parameter logic [IDX_W-1:0]    FEAT_IDX   = 16'h1107,
  parameter int unsigned         EN_BIT     = 0,
  parameter logic [DW-1:0]       FIXED_BITS = 32'h0000_00A2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             priv_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             en_o,
  output logic [DW-1:0]    rdata_o,
  output logic             prot_fault_o
);
  localparam logic [DW-1:0] EN_MASK = DW'(1) << EN_BIT;
  localparam logic [DW-1:0] FIXED_M = FIXED_BITS & ~EN_MASK;

  logic en_q, fault_q;
  logic hit;

  assign hit = we_i && (idx_i == FEAT_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= hit && !priv_i;
      if (hit && priv_i) en_q <= wdata_i[EN_BIT];
    end
  end

  assign en_o         = en_q;
  assign rdata_o      = FIXED_M | (en_q ? EN_MASK : '0);
  assign prot_fault_o = fault_q;
endmodule

// File: rtl/abd_launch.sv
module abd_launch #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_hit_i,
  input  logic          en_i,
  input  logic [AW-1:0] acc_i,
  output logic          redirect_valid_o,
  output logic [AW-1:0] redirect_addr_o,
  output logic          ud_fault_o,
  output logic          mode_o
);
  logic          rv_q, ud_q, mode_q;
  logic [AW-1:0] ra_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q   <= 1'b0;
      ra_q   <= '0;
      ud_q   <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      rv_q <= launch_hit_i && en_i;
      ud_q <= launch_hit_i && !en_i;
      ra_q <= (launch_hit_i && en_i) ? acc_i : '0;
      if (launch_hit_i && en_i) mode_q <= 1'b1;
    end
  end

  assign redirect_valid_o = rv_q;
  assign redirect_addr_o  = ra_q;
  assign ud_fault_o       = ud_q;
  assign mode_o           = mode_q;
endmodule

// File: rtl/alt_bridge_decoder.sv
module alt_bridge_decoder #(
  parameter int unsigned      PAY_BYTES  = 4,
  parameter int unsigned      AW         = 32,
  parameter int unsigned      DW         = 32,
  parameter int unsigned      IDX_W      = 16,
  parameter logic [IDX_W-1:0] FEAT_IDX   = 16'h1107,
  parameter int unsigned      EN_BIT     = 0,
  parameter logic [DW-1:0]    FIXED_BITS = 32'h0000_00A2,
  parameter logic [15:0]      LAUNCH_OP  = 16'h0F3F,
  parameter logic [7:0]       PFX_A0     = 8'h8D,
  parameter logic [7:0]       PFX_A1     = 8'h84,
  parameter logic [7:0]       PFX_A2     = 8'h00,
  parameter logic [7:0]       PFX_B0     = 8'h62,
  parameter logic [7:0]       PFX_B1     = 8'h04,
  parameter logic [7:0]       PFX_B2     = 8'h05
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   byte_valid_i,
  input  logic [7:0]             byte_i,
  input  logic [AW-1:0]          acc_i,
  input  logic                   csr_we_i,
  input  logic                   csr_priv_i,
  input  logic [IDX_W-1:0]       csr_idx_i,
  input  logic [DW-1:0]          csr_wdata_i,
  output logic [DW-1:0]          csr_rdata_o,
  output logic                   prot_fault_o,
  output logic                   insn_valid_o,
  output logic [8*PAY_BYTES-1:0] insn_o,
  output logic                   redirect_valid_o,
  output logic [AW-1:0]          redirect_addr_o,
  output logic                   ud_fault_o,
  output logic                   alt_mode_o
);
  localparam int unsigned W = 8 * PAY_BYTES;

  logic         wrap_hit, launch_hit, en;
  logic [W-1:0] word;
  logic         iv_q;
  logic [W-1:0] insn_q;

  abd_matcher #(
    .PFX_A0(PFX_A0), .PFX_A1(PFX_A1), .PFX_A2(PFX_A2),
    .PFX_B0(PFX_B0), .PFX_B1(PFX_B1), .PFX_B2(PFX_B2),
    .LAUNCH_OP(LAUNCH_OP), .PAY_BYTES(PAY_BYTES)
  ) u_matcher (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .wrap_hit_o   (wrap_hit),
    .word_o       (word),
    .launch_hit_o (launch_hit)
  );

  abd_feature_reg #(
    .IDX_W(IDX_W), .DW(DW), .FEAT_IDX(FEAT_IDX),
    .EN_BIT(EN_BIT), .FIXED_BITS(FIXED_BITS)
  ) u_freg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (csr_we_i),
    .priv_i       (csr_priv_i),
    .idx_i        (csr_idx_i),
    .wdata_i      (csr_wdata_i),
    .en_o         (en),
    .rdata_o      (csr_rdata_o),
    .prot_fault_o (prot_fault_o)
  );

  abd_launch #(.AW(AW)) u_launch (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .launch_hit_i     (launch_hit),
    .en_i             (en),
    .acc_i            (acc_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_addr_o  (redirect_addr_o),
    .ud_fault_o       (ud_fault_o),
    .mode_o           (alt_mode_o)
  );

  // wrappers outside alternate mode are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iv_q   <= 1'b0;
      insn_q <= '0;
    end else begin
      iv_q <= wrap_hit && alt_mode_o;
      if (wrap_hit && alt_mode_o) insn_q <= word;
    end
  end

  assign insn_valid_o = iv_q;
  assign insn_o       = insn_q;
endmodule

// File: rtl/abd_checker.sv
module abd_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          insn_valid_o,
  input logic          redirect_valid_o,
  input logic [AW-1:0] redirect_addr_o,
  input logic          ud_fault_o,
  input logic          prot_fault_o,
  input logic          alt_mode_o,
  input logic [DW-1:0] csr_rdata_o
);
  // R2
  insn_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o |=> !insn_valid_o);
  // R5
  insn_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_valid_o |-> alt_mode_o);
  // R6
  redir_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |-> alt_mode_o);
  // R6
  redir_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_valid_o |=> !redirect_valid_o);
  // R6
  redir_addr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_valid_o |-> redirect_addr_o == '0);
  // R6
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(alt_mode_o));
  // R7
  ud_no_redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_fault_o |-> !redirect_valid_o && $stable(alt_mode_o));
  // R9
  prot_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> $stable(csr_rdata_o));
endmodule

bind alt_bridge_decoder abd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .insn_valid_o     (insn_valid_o),
  .redirect_valid_o (redirect_valid_o),
  .redirect_addr_o  (redirect_addr_o),
  .ud_fault_o       (ud_fault_o),
  .prot_fault_o     (prot_fault_o),
  .alt_mode_o       (alt_mode_o),
  .csr_rdata_o      (csr_rdata_o)
);

// File: tb/alt_bridge_decoder_bench.sv
module alt_bridge_decoder_bench;
  localparam logic [31:0] FIXED = 32'h0000_00A2;
  localparam int K_INSN = 0, K_REDIR = 1, K_UD = 2, K_PROT = 3;

  typedef struct {
    int          kind;
    logic [31:0] data;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_i = '0;
  logic [31:0] acc_i = '0;
  logic        csr_we_i = 1'b0;
  logic        csr_priv_i = 1'b0;
  logic [15:0] csr_idx_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        prot_fault_o, insn_valid_o, redirect_valid_o, ud_fault_o, alt_mode_o;
  logic [31:0] insn_o, redirect_addr_o;

  int    checks = 0;
  int    fails = 0;
  int    ev_cnt = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  alt_bridge_decoder u_alt_bridge_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
    .acc_i(acc_i), .csr_we_i(csr_we_i), .csr_priv_i(csr_priv_i),
    .csr_idx_i(csr_idx_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .prot_fault_o(prot_fault_o), .insn_valid_o(insn_valid_o), .insn_o(insn_o),
    .redirect_valid_o(redirect_valid_o), .redirect_addr_o(redirect_addr_o),
    .ud_fault_o(ud_fault_o), .alt_mode_o(alt_mode_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input logic [31:0] data, input string req);
    item_t it;
    it.kind = kind; it.data = data; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic pop_cmp(input int kind, input logic [31:0] data);
    item_t it;
    ev_cnt++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", 32'(kind), 32'hFFFF_FFFF);
    end else begin
      it = exp_q.pop_front();
      chk(it.kind == kind && it.data == data, it.req, data, it.data);
    end
  endtask

  // monitor: outputs settle after posedge, sample at negedge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (insn_valid_o)     pop_cmp(K_INSN, insn_o);
      if (redirect_valid_o) pop_cmp(K_REDIR, redirect_addr_o);
      if (ud_fault_o)       pop_cmp(K_UD, 32'h0);
      if (prot_fault_o)     pop_cmp(K_PROT, 32'h0);
    end
  end

  task automatic send_byte(input logic [7:0] b);
    byte_valid_i = 1'b1;
    byte_i = b;
    @(negedge clk);
    byte_valid_i = 1'b0;
    byte_i = 8'h84;
  endtask

  task automatic send_wrap(input logic [23:0] pfx, input logic [31:0] w);
    send_byte(pfx[23:16]); send_byte(pfx[15:8]); send_byte(pfx[7:0]);
    for (int i = 0; i < 4; i++) send_byte(w[8*i +: 8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_write(input logic [15:0] idx, input logic [31:0] d, input logic priv);
    csr_we_i = 1'b1; csr_idx_i = idx; csr_wdata_i = d; csr_priv_i = priv;
    @(negedge clk);
    csr_we_i = 1'b0; csr_priv_i = 1'b0;
  endtask

  task automatic finish_run();
    chk(exp_q.size() == 0, "pending expected events", 32'(exp_q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e0;
    idle(3);
    // R1 reset state
    chk(!insn_valid_o && !redirect_valid_o && !ud_fault_o && !prot_fault_o, "R1 pulses",
        {28'h0, insn_valid_o, redirect_valid_o, ud_fault_o, prot_fault_o}, 32'h0);
    chk(!alt_mode_o, "R1 mode", 32'(alt_mode_o), 32'h0);
    chk(csr_rdata_o == FIXED, "R1 rdata", csr_rdata_o, FIXED);
    rst_ni = 1'b1;
    idle(2);

    // R7 launch while disabled
    acc_i = 32'h0000_4000;
    expect_ev(K_UD, 32'h0, "R7 fault");
    send_byte(8'h0F); send_byte(8'h3F);
    idle(2);
    chk(!alt_mode_o, "R7 mode kept", 32'(alt_mode_o), 32'h0);

    // R5 wrapper outside mode
    e0 = ev_cnt;
    send_wrap(24'h8D8400, 32'h4433_2211);
    idle(2);
    chk(ev_cnt == e0, "R5 no insn", 32'(ev_cnt - e0), 32'h0);

    // R9 unprivileged write
    expect_ev(K_PROT, 32'h0, "R9 prot fault");
    csr_write(16'h1107, 32'hFFFF_FFFF, 1'b0);
    idle(1);
    chk(csr_rdata_o == FIXED, "R9 unchanged", csr_rdata_o, FIXED);

    // R10 other index
    e0 = ev_cnt;
    csr_write(16'h1108, 32'hFFFF_FFFF, 1'b1);
    idle(1);
    chk(csr_rdata_o == FIXED && ev_cnt == e0, "R10 ignored", csr_rdata_o, FIXED);

    // R8 privileged RMW sets bit 0 only
    csr_write(16'h1107, 32'h5A5A_0001, 1'b1);
    chk(csr_rdata_o == (FIXED | 32'h1), "R8 set", csr_rdata_o, FIXED | 32'h1);

    // R6 launch enabled
    acc_i = 32'h0040_1000;
    expect_ev(K_REDIR, 32'h0040_1000, "R6 redirect");
    send_byte(8'h0F); send_byte(8'h3F);
    chk(alt_mode_o, "R6 mode", 32'(alt_mode_o), 32'h1);
    idle(1);

    // R2 primary prefix, little-endian
    expect_ev(K_INSN, 32'h4433_2211, "R2 primary");
    send_wrap(24'h8D8400, 32'h4433_2211);
    idle(1);
    // R3 second prefix
    expect_ev(K_INSN, 32'hDEAD_BEEF, "R3 second");
    send_wrap(24'h620405, 32'hDEAD_BEEF);
    idle(1);

    // R4 restart on repeated 8D
    expect_ev(K_INSN, 32'h0102_0304, "R4 8D restart");
    send_byte(8'h8D);
    send_wrap(24'h8D8400, 32'h0102_0304);
    idle(1);
    // R4 second prefix broken by first prefix
    expect_ev(K_INSN, 32'hCAFE_0062, "R4 62 04 8D");
    send_byte(8'h62); send_byte(8'h04);
    send_wrap(24'h8D8400, 32'hCAFE_0062);
    idle(1);
    // R4 first prefix broken by 62
    expect_ev(K_INSN, 32'h7788_99AA, "R4 8D 84 62");
    send_byte(8'h8D); send_byte(8'h84);
    send_wrap(24'h620405, 32'h7788_99AA);
    idle(1);
    // R4 non-start breaking byte returns to idle
    e0 = ev_cnt;
    send_byte(8'h8D); send_byte(8'h17); send_byte(8'h84); send_byte(8'h00);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
    idle(2);
    chk(ev_cnt == e0, "R4 idle after break", 32'(ev_cnt - e0), 32'h0);

    // R11 gaps with byte_valid_i low
    expect_ev(K_INSN, 32'h1234_5678, "R11 gaps");
    send_byte(8'h8D); idle(3);
    send_byte(8'h84); idle(2);
    send_byte(8'h00); send_byte(8'h78); idle(4);
    send_byte(8'h56); send_byte(8'h34); idle(1); send_byte(8'h12);
    idle(1);

    // R8 clear bit, R7 fault keeps mode high
    csr_write(16'h1107, 32'hFFFF_FFFE, 1'b1);
    chk(csr_rdata_o == FIXED, "R8 clear", csr_rdata_o, FIXED);
    expect_ev(K_UD, 32'h0, "R7 fault in mode");
    send_byte(8'h0F); send_byte(8'h3F);
    idle(2);
    chk(alt_mode_o, "R7 mode stays", 32'(alt_mode_o), 32'h1);

    idle(3);
    finish_run();
  end
endmodule